// File: doc/BRIEF.md
# Accumulator CPU microsequencer

This block is the control and datapath core of a small decimal-addressed accumulator machine. Every instruction word is read as a number from 0 to 999. The hundreds digit selects the operation, and the remaining two digits name one of 100 memory cells. The core steps each instruction through a fixed chain of register transfers, one transfer per clock. The transfers move values among a program counter, a memory address register, the memory read data, an instruction register, the accumulator, a shared I/O register, a write-data register and a stack pointer.

The core drives an external synchronous word memory. Address and write data come from registers. Write enable is a registered one-cycle pulse. Read data returns one clock after an address is presented, and that read data serves as the memory data register. A device loads the I/O register through an input strobe. An OUT instruction copies the accumulator into the same register and strobes it outward. A HALT instruction parks the core until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, `halted`, `out_valid` and `mem_we` are low. Reset clears the PC, the accumulator, the address register and the halted flag, and it sets the stack pointer to `SP_INIT`. The first step after reset presents address 0.
- R2: Every instruction begins with three steps: PC to address register, a memory read, then read data to the instruction register. The words 1nn (add) and 2nn (subtract) take 7 cycles in total, 5nn (load) 7, 3nn (store) 7, 6nn/7nn/8nn (branches) 4, 901 (input) 5, 902 (output) 5, 903 (negate) 6 and 4nn (push) 8. Any other code takes 4.
- R3: Add, subtract and load set the accumulator to A+M[nn], A−M[nn] or M[nn], with wrap-around modulo 2^DATA_W.
- R4: Store (3nn) writes the accumulator to cell nn with one single-cycle `mem_we` pulse. No other instruction except push ever asserts `mem_we`.
- R5: 6nn always loads nn into the PC. 7nn branches only when the accumulator is zero. 8nn branches only when the accumulator sign bit is clear, which includes zero. An untaken branch advances the PC.
- R6: An `in_valid` cycle loads `in_data` into the I/O register. 901 copies that register into the accumulator and makes no memory access.
- R7: 902 copies the accumulator to the I/O register, which drives `out_data`. `out_valid` is high for exactly one cycle per 902.
- R8: 903 replaces the accumulator with its two's complement by inverting it and then adding one. Negating 0 gives 0, and negating the most negative value gives that same value back.
- R9: Push (4nn; the nn digits are ignored) advances the PC, writes the new PC (the address after the push) to the cell the stack pointer names, and then advances the stack pointer. The accumulator is unchanged. The stack pointer wraps from 99 to 0.
- R10: 0nn halts. `halted` rises after the fetch, stays high, and the PC never advances again. No further write, output or fetch takes place, and `mem_addr` stays at the halt word's address.
- R11: The PC advances modulo 100, so the word after cell 99 is fetched from cell 0. `mem_addr` never exceeds 99.
- R12: An unused code (900, 904 to 999, or a word of 1000 or more) changes neither the accumulator nor memory and only advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | Memory address (address register) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable, one cycle per write |
| mem_rdata | input | DATA_W | Memory read data, one cycle after address |
| in_data | input | DATA_W | Value offered to the I/O register |
| in_valid | input | 1 | Loads `in_data` into the I/O register |
| out_data | output | DATA_W | Current I/O register contents |
| out_valid | output | 1 | One-cycle strobe after an output instruction |
| halted | output | 1 | Core has executed a halt |

## Verification
The bench builds the core with DATA_W=16, ADDR_W=7 and SP_INIT=80. A 16-bit accumulator lets a short program add across 32767 and negate 32768, which exercises wrap-around and the most-negative corner. A stack base of 80 keeps the stack above the test code, so twenty-two pushes fill cells 80 to 99 and then wrap into cells 0 and 1. The bench measures the cycle gaps between output strobes, which confirms the per-instruction step counts.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // decimal addressing: two address digits
  localparam int CELLS = 100;

  typedef enum logic [4:0] {
    S_FETCH, S_MEMRD, S_LOADIR,
    S_OPADDR, S_OPRD, S_ALU,
    S_STDATA, S_STWR,
    S_BRANCH, S_IN, S_OUT,
    S_NEG1, S_NEG2,
    S_PUSHPC, S_PUSHMAR, S_PUSHMDR, S_PUSHWR, S_PUSHSP,
    S_INCPC, S_HALT
  } step_e;

  typedef enum logic [3:0] {
    OP_HALT, OP_ADD, OP_SUB, OP_STORE, OP_PUSH, OP_LOAD,
    OP_BR, OP_BRZ, OP_BRP, OP_IN, OP_OUT, OP_NEG, OP_NOP
  } op_e;

  typedef enum logic [2:0] {
    ALU_PASS, ALU_ADD, ALU_SUB, ALU_INV, ALU_INC
  } alu_fn_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic [DATA_W-1:0] word,
  output op_e               op,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [DATA_W-1:0] RADIX = DATA_W'(CELLS);

  logic [DATA_W-1:0] lead;

  assign lead = word / RADIX;
  assign addr = ADDR_W'(word % RADIX);

  always_comb begin
    op = OP_NOP;
    case (lead)
      DATA_W'(0): op = OP_HALT;
      DATA_W'(1): op = OP_ADD;
      DATA_W'(2): op = OP_SUB;
      DATA_W'(3): op = OP_STORE;
      DATA_W'(4): op = OP_PUSH;
      DATA_W'(5): op = OP_LOAD;
      DATA_W'(6): op = OP_BR;
      DATA_W'(7): op = OP_BRZ;
      DATA_W'(8): op = OP_BRP;
      DATA_W'(9): begin
        case (addr)
          ADDR_W'(1): op = OP_IN;
          ADDR_W'(2): op = OP_OUT;
          ADDR_W'(3): op = OP_NEG;
          default:    op = OP_NOP;
        endcase
      end
      default: op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_fn_e           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_INV: y = ~a;
      ALU_INC: y = a + DATA_W'(1);
      default: y = b;
    endcase
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  op_e   op_mdr,
  input  op_e   op_ir,
  output step_e step,
  output step_e step_nx
);

  always_comb begin
    step_nx = step;
    case (step)
      S_FETCH:  step_nx = S_MEMRD;
      S_MEMRD:  step_nx = S_LOADIR;
      S_LOADIR: begin
        case (op_mdr)
          OP_HALT:                          step_nx = S_HALT;
          OP_ADD, OP_SUB, OP_LOAD, OP_STORE: step_nx = S_OPADDR;
          OP_BR, OP_BRZ, OP_BRP:            step_nx = S_BRANCH;
          OP_IN:                            step_nx = S_IN;
          OP_OUT:                           step_nx = S_OUT;
          OP_NEG:                           step_nx = S_NEG1;
          OP_PUSH:                          step_nx = S_PUSHPC;
          default:                          step_nx = S_INCPC;
        endcase
      end
      S_OPADDR:  step_nx = (op_ir == OP_STORE) ? S_STDATA : S_OPRD;
      S_OPRD:    step_nx = S_ALU;
      S_ALU:     step_nx = S_INCPC;
      S_STDATA:  step_nx = S_STWR;
      S_STWR:    step_nx = S_INCPC;
      S_BRANCH:  step_nx = S_FETCH;
      S_IN:      step_nx = S_INCPC;
      S_OUT:     step_nx = S_INCPC;
      S_NEG1:    step_nx = S_NEG2;
      S_NEG2:    step_nx = S_INCPC;
      S_PUSHPC:  step_nx = S_PUSHMAR;
      S_PUSHMAR: step_nx = S_PUSHMDR;
      S_PUSHMDR: step_nx = S_PUSHWR;
      S_PUSHWR:  step_nx = S_PUSHSP;
      S_PUSHSP:  step_nx = S_FETCH;
      S_INCPC:   step_nx = S_FETCH;
      S_HALT:    step_nx = S_HALT;
      default:   step_nx = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= S_FETCH;
    else     step <= step_nx;
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 7,
  parameter int SP_INIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(CELLS - 1);
  localparam logic [ADDR_W-1:0] SP_RESET  = ADDR_W'(SP_INIT);
  localparam int                PAD_W     = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, mar_q, sp_q;
  logic [DATA_W-1:0] ir_q, acc_q, ior_q, wdr_q;
  logic              we_q, outv_q, halt_q;

  step_e             step, step_nx;
  op_e               op_mdr, op_ir;
  logic [ADDR_W-1:0] unused_mdr_addr;
  logic [ADDR_W-1:0] ir_addr;
  logic [ADDR_W-1:0] pc_next, sp_next;
  alu_fn_e           alu_fn;
  logic [DATA_W-1:0] alu_y;
  logic              taken;

  // decode of the fresh read word picks the execute path
  acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec_mdr (
    .word (mem_rdata),
    .op   (op_mdr),
    .addr (unused_mdr_addr)
  );

  // decode of the held instruction feeds operand steps
  acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec_ir (
    .word (ir_q),
    .op   (op_ir),
    .addr (ir_addr)
  );

  acc_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .op_mdr  (op_mdr),
    .op_ir   (op_ir),
    .step    (step),
    .step_nx (step_nx)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .fn (alu_fn),
    .a  (acc_q),
    .b  (mem_rdata),
    .y  (alu_y)
  );

  assign pc_next = (pc_q == LAST_CELL) ? '0 : pc_q + ADDR_W'(1);
  assign sp_next = (sp_q == LAST_CELL) ? '0 : sp_q + ADDR_W'(1);

  always_comb begin
    case (op_ir)
      OP_BR:   taken = 1'b1;
      OP_BRZ:  taken = (acc_q == '0);
      OP_BRP:  taken = ~acc_q[DATA_W-1];
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    alu_fn = ALU_PASS;
    case (step)
      S_ALU: begin
        if (op_ir == OP_ADD)      alu_fn = ALU_ADD;
        else if (op_ir == OP_SUB) alu_fn = ALU_SUB;
        else                      alu_fn = ALU_PASS;
      end
      S_NEG1:  alu_fn = ALU_INV;
      S_NEG2:  alu_fn = ALU_INC;
      default: alu_fn = ALU_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      mar_q  <= '0;
      sp_q   <= SP_RESET;
      ir_q   <= '0;
      acc_q  <= '0;
      ior_q  <= '0;
      wdr_q  <= '0;
      we_q   <= 1'b0;
      outv_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      we_q   <= (step_nx == S_STWR) || (step_nx == S_PUSHWR);
      outv_q <= (step == S_OUT);
      halt_q <= (step_nx == S_HALT);
      if (in_valid && step != S_OUT) ior_q <= in_data;
      case (step)
        S_FETCH:   mar_q <= pc_q;
        S_LOADIR:  ir_q  <= mem_rdata;
        S_OPADDR:  mar_q <= ir_addr;
        S_ALU:     acc_q <= alu_y;
        S_STDATA:  wdr_q <= acc_q;
        S_BRANCH:  pc_q  <= taken ? ir_addr : pc_next;
        S_IN:      acc_q <= ior_q;
        S_OUT:     ior_q <= acc_q;
        S_NEG1:    acc_q <= alu_y;
        S_NEG2:    acc_q <= alu_y;
        S_PUSHPC:  pc_q  <= pc_next;
        S_PUSHMAR: mar_q <= sp_q;
        S_PUSHMDR: wdr_q <= {{PAD_W{1'b0}}, pc_q};
        S_PUSHSP:  sp_q  <= sp_next;
        S_INCPC:   pc_q  <= pc_next;
        default:   ;
      endcase
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = wdr_q;
  assign mem_we    = we_q;
  assign out_data  = ior_q;
  assign out_valid = outv_q;
  assign halted    = halt_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              out_valid,
  input logic              halted,
  input logic [ADDR_W-1:0] sp,
  input logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(CELLS - 1);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_we && !out_valid));

  // R10
  halt_pc_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc) && $stable(mem_addr));

  // R4
  write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R11
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_addr <= TOP);

  // R9
  sp_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp) |-> (sp == (($past(sp) == TOP) ? '0 : $past(sp) + ADDR_W'(1))));

endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .out_valid (out_valid),
  .halted    (halted),
  .sp        (sp_q),
  .pc        (pc_q)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 7;
  localparam int SP_INIT    = 80;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;
  logic              halted;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_valid(in_valid), .out_data(out_data), .out_valid(out_valid),
    .halted(halted)
  );

  // synchronous memory model, one-cycle read
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  typedef struct {
    logic [DATA_W-1:0] val;
    int                gap;
    string             req;
  } exp_t;

  exp_t sb[$];
  exp_t got;
  int total = 0, bad = 0, cyc = 0, last_out = 0, writes = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(int v, int gap, string req);
    exp_t e;
    e.val = DATA_W'(v);
    e.gap = gap;
    e.req = req;
    sb.push_back(e);
  endtask

  function automatic int neg(int v);
    return int'(DATA_W'(~DATA_W'(v) + DATA_W'(1)));
  endfunction

  task automatic put(int a, int v);
    mem[a] <= DATA_W'(v);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
  endtask

  // monitor: pops scoreboard items as outputs appear
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0;
      writes = 0;
      last_out = 0;
    end else begin
      cyc++;
      if (mem_we) writes++;
      if (out_valid) begin
        if (sb.size() == 0) begin
          check_eq("R7", "unexpected out_valid", int'(out_data), -1);
        end else begin
          got = sb.pop_front();
          check_eq(got.req, "output value", int'(out_data), int'(got.val));
          if (got.gap != 0)
            check_eq(got.req, "cycles between outputs", cyc - last_out, got.gap);
          last_out = cyc;
        end
      end
    end
  end

  task automatic finish_prog(int halt_addr, int exp_writes);
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    check_eq("R10", "halted", int'(halted), 1);
    check_eq("R10", "address parked at halt word", int'(mem_addr), halt_addr);
    check_eq("R4", "write count", writes, exp_writes);
    check_eq("R7", "outputs left unseen", sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // ---------- program A: arithmetic, I/O, negate, store, unused codes
    rst = 1'b1;
    @(negedge clk);
    clear_mem();
    put(0, 902); put(1, 904); put(2, 901); put(3, 905); put(4, 902);
    put(5, 160); put(6, 261); put(7, 370); put(8, 562); put(9, 160);
    put(10, 902); put(11, 903); put(12, 902); put(13, 563); put(14, 903);
    put(15, 902); put(16, 564); put(17, 903); put(18, 902); put(19, 371);
    put(20, 0);
    put(60, 1000); put(61, 30); put(62, 32767); put(63, 0); put(64, 32768);
    expect_out(0, 0, "R1");                     // accumulator cleared
    expect_out(25, 18, "R6 R12 R2");            // input, unused codes, timing
    expect_out(33767, 40, "R3 R2");             // wrap past 32767
    expect_out(neg(33767), 11, "R8 R2");
    expect_out(0, 18, "R8");                    // negate zero
    expect_out(32768, 18, "R8");                // most negative
    repeat (2) @(negedge clk);
    check_eq("R1", "halted in reset", int'(halted), 0);
    check_eq("R1", "out_valid in reset", int'(out_valid), 0);
    check_eq("R1", "mem_we in reset", int'(mem_we), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "first fetch address", int'(mem_addr), 0);
    repeat (4) @(negedge clk);
    in_data = DATA_W'(25);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    finish_prog(20, 2);
    check_eq("R4", "stored a-b sum", int'(mem[70]), 995);
    check_eq("R4", "stored negated min", int'(mem[71]), 32768);
    check_eq("R12", "cell 61 untouched", int'(mem[61]), 30);

    // ---------- program B: branches, PC wrap, push
    rst = 1'b1;
    @(negedge clk);
    clear_mem();
    put(0, 797); put(97, 595); put(98, 902); put(99, 904);
    put(1, 902); put(2, 805); put(3, 902); put(4, 0); put(5, 903);
    put(6, 810); put(7, 712); put(8, 902); put(9, 611); put(10, 0);
    put(11, 400); put(12, 400); put(13, 902); put(14, 596); put(15, 817);
    put(16, 0); put(17, 720); put(18, 0); put(19, 0); put(20, 902);
    put(21, 0);
    put(95, 7); put(96, 0);
    expect_out(7, 0, "R5 R1");                  // BRZ taken after reset
    expect_out(7, 13, "R11 R5");                // wrap 99 -> 0, BRZ untaken
    expect_out(neg(7), 23, "R5");               // BRP/BRZ untaken on negative
    expect_out(neg(7), 25, "R9 R2");            // push keeps A, 8 cycles each
    expect_out(0, 20, "R5");                    // BRP taken on zero
    repeat (2) @(negedge clk);
    rst = 1'b0;
    finish_prog(21, 2);
    check_eq("R9", "first push value", int'(mem[80]), 12);
    check_eq("R9", "second push value", int'(mem[81]), 13);

    // ---------- program C: stack pointer wrap
    rst = 1'b1;
    @(negedge clk);
    clear_mem();
    for (int i = 0; i < 22; i++) put(i, 400);
    put(22, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    finish_prog(22, 22);
    check_eq("R9", "stack base cell", int'(mem[80]), 1);
    check_eq("R9", "stack top cell", int'(mem[99]), 20);
    check_eq("R9", "wrapped to cell 0", int'(mem[0]), 21);
    check_eq("R9", "then cell 1", int'(mem[1]), 22);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule